// File: doc/BRIEF.md
# Serial Display Link Bring-Up Sequencer

This block powers up a serial display link and the PLL behind it, and later shuts them down, through a fixed sequence of control outputs. A start pulse turns on the free-running pixel clock and then raises the PLL system-reset control. After a short settle time it raises the PLL go request. The block then waits in three stages: for the go acknowledge, for PLL lock, and for the link reset to finish. The LCD output enable comes on between the second and third stages.

Each wait stage has its own timeout counter. When a stage times out, the outputs are unwound in reverse order, and how far back the unwind starts depends on which stage failed. The error is then latched in a sticky flag. A stop pulse shuts down a link that is up in a different fixed order: LCD first, then the pixel clock, then the PLL reset control. The timeout and settle lengths are parameters given in clock cycles.

Top module: `link_bringup_seq`

## Requirements
- R1: After reset, every output is low.
- R2: A start pulse in idle raises pclk_free_o on the next edge and pll_rst_o one cycle later. pll_go_o rises exactly SETTLE_CYCLES cycles after pll_rst_o.
- R3: pll_go_o stays high until go_pend_i is sampled low. It falls on that edge, and the lock stage begins.
- R4: lcd_en_o rises only on an edge where locked_i is high. done_o rises, and busy_o falls, on the edge where link_ok_i is sampled high during the link stage.
- R5: A wait stage whose status has not arrived by its TMO_CYCLES-th cycle times out on that cycle's closing edge. A status seen on that same edge counts as success.
- R6: A timeout in the go stage or the lock stage drops pll_rst_o and pll_go_o on the timeout edge. pclk_free_o drops one cycle later, on the same edge where err_o rises and busy_o falls.
- R7: A timeout in the link stage drops lcd_en_o first, on the timeout edge. The R6 steps follow, one cycle each.
- R8: A stop pulse, taken in idle or with the link up, clears done_o and drops lcd_en_o at once. pclk_free_o follows one cycle later, then pll_rst_o one cycle after that, together with busy_o.
- R9: A start pulse has no effect while busy_o is high or while the link is up. A stop pulse has no effect during bring-up.
- R10: err_o stays high until the next accepted start or stop, and either of these clears it.
- R11: When start and stop arrive in the same cycle in idle, stop wins and no bring-up begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start bring-up (one-cycle pulse) |
| stop_i | input | 1 | Disable link (one-cycle pulse) |
| go_pend_i | input | 1 | PLL go request still pending |
| locked_i | input | 1 | PLL locked |
| link_ok_i | input | 1 | Link reset complete |
| pclk_free_o | output | 1 | Free-running pixel clock enable |
| pll_rst_o | output | 1 | PLL system-reset control, high while the link is in use |
| pll_go_o | output | 1 | PLL go request |
| lcd_en_o | output | 1 | LCD output enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Link is up |
| err_o | output | 1 | Sticky timeout flag |

## Verification
Two pairs of events can land in the same cycle. The first pair is a stage's status arriving and that stage's timeout expiring. The bench models the link with a programmable reset-complete latency. It sets that latency to exactly TMO_CYCLES and expects success with an 8-cycle gap; one cycle more must give the link-stage unwind. The second pair is start and stop arriving together in idle, pulsed on one edge. The scoreboard then has to see the short stop sequence and no pixel clock.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RSTON,
    ST_SETTLE,
    ST_GO,
    ST_LOCK,
    ST_LINK,
    ST_UP,
    ST_ERR_RST,
    ST_ERR_CLK,
    ST_DIS_CLK,
    ST_DIS_RST
  } lbs_state_e;

  typedef struct packed {
    logic pclk;
    logic rst;
    logic go;
    logic lcd;
    logic busy;
    logic done;
    logic err;
  } lbs_out_t;

  // Stages whose duration is bounded by the timeout counter
  function automatic logic lbs_is_wait(lbs_state_e s);
    return (s == ST_GO) || (s == ST_LOCK) || (s == ST_LINK);
  endfunction

  // Width of a counter that reaches limit-1
  function automatic int unsigned lbs_cnt_w(int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/lbs_cycle_timer.sv
module lbs_cycle_timer #(
  parameter int unsigned LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int unsigned CW = lbs_pkg::lbs_cnt_w(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (en && cnt != LAST)  cnt <= cnt + 1'b1;
  end

  // Fires in the LIMIT-th enabled cycle after a clear
  assign hit = en && (cnt == LAST);
endmodule

// File: rtl/lbs_seq_fsm.sv
module lbs_seq_fsm
  import lbs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     stop,
  input  logic     go_pend,
  input  logic     locked,
  input  logic     link_ok,
  input  logic     settle_hit,
  input  logic     tmo_hit,
  output lbs_out_t q,
  output logic     settle_en,
  output logic     tmo_en,
  output logic     phase_clr
);
  lbs_state_e st, nxt;
  lbs_out_t   d;

  always_comb begin
    nxt = st;
    d   = q;
    unique case (st)
      ST_IDLE: begin
        if (stop) begin
          d.lcd = 1'b0; d.busy = 1'b1; d.done = 1'b0; d.err = 1'b0;
          nxt = ST_DIS_CLK;
        end else if (start) begin
          d.pclk = 1'b1; d.busy = 1'b1; d.done = 1'b0; d.err = 1'b0;
          nxt = ST_RSTON;
        end
      end
      ST_RSTON: begin
        d.rst = 1'b1;
        nxt = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (settle_hit) begin
          d.go = 1'b1;
          nxt = ST_GO;
        end
      end
      ST_GO: begin
        if (!go_pend) begin
          d.go = 1'b0;
          nxt = ST_LOCK;
        end else if (tmo_hit) begin
          d.rst = 1'b0; d.go = 1'b0;
          nxt = ST_ERR_CLK;
        end
      end
      ST_LOCK: begin
        if (locked) begin
          d.lcd = 1'b1;
          nxt = ST_LINK;
        end else if (tmo_hit) begin
          d.rst = 1'b0; d.go = 1'b0;
          nxt = ST_ERR_CLK;
        end
      end
      ST_LINK: begin
        if (link_ok) begin
          d.done = 1'b1; d.busy = 1'b0;
          nxt = ST_UP;
        end else if (tmo_hit) begin
          d.lcd = 1'b0;
          nxt = ST_ERR_RST;
        end
      end
      ST_UP: begin
        if (stop) begin
          d.lcd = 1'b0; d.done = 1'b0; d.busy = 1'b1;
          nxt = ST_DIS_CLK;
        end
      end
      ST_ERR_RST: begin
        d.rst = 1'b0; d.go = 1'b0;
        nxt = ST_ERR_CLK;
      end
      ST_ERR_CLK: begin
        d.pclk = 1'b0; d.err = 1'b1; d.busy = 1'b0;
        nxt = ST_IDLE;
      end
      ST_DIS_CLK: begin
        d.pclk = 1'b0;
        nxt = ST_DIS_RST;
      end
      ST_DIS_RST: begin
        d.rst = 1'b0; d.busy = 1'b0;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      q  <= '0;
    end else begin
      st <= nxt;
      q  <= d;
    end
  end

  assign settle_en = (st == ST_SETTLE);
  assign tmo_en    = lbs_is_wait(st);
  assign phase_clr = (nxt != st);
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq #(
  parameter int unsigned SETTLE_CYCLES = 2,
  parameter int unsigned TMO_CYCLES    = 50000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic go_pend_i,
  input  logic locked_i,
  input  logic link_ok_i,
  output logic pclk_free_o,
  output logic pll_rst_o,
  output logic pll_go_o,
  output logic lcd_en_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);
  import lbs_pkg::*;

  lbs_out_t q;
  logic settle_en, settle_hit;
  logic tmo_en, tmo_hit;
  logic phase_clr;

  lbs_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .stop       (stop_i),
    .go_pend    (go_pend_i),
    .locked     (locked_i),
    .link_ok    (link_ok_i),
    .settle_hit (settle_hit),
    .tmo_hit    (tmo_hit),
    .q          (q),
    .settle_en  (settle_en),
    .tmo_en     (tmo_en),
    .phase_clr  (phase_clr)
  );

  lbs_cycle_timer #(.LIMIT(SETTLE_CYCLES)) u_settle (
    .clk (clk), .rst_n (rst_n), .clr (phase_clr), .en (settle_en), .hit (settle_hit)
  );

  lbs_cycle_timer #(.LIMIT(TMO_CYCLES)) u_tmo (
    .clk (clk), .rst_n (rst_n), .clr (phase_clr), .en (tmo_en), .hit (tmo_hit)
  );

  assign pclk_free_o = q.pclk;
  assign pll_rst_o   = q.rst;
  assign pll_go_o    = q.go;
  assign lcd_en_o    = q.lcd;
  assign busy_o      = q.busy;
  assign done_o      = q.done;
  assign err_o       = q.err;
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic stop_i,
  input logic go_pend_i,
  input logic locked_i,
  input logic link_ok_i,
  input logic pclk_free_o,
  input logic pll_rst_o,
  input logic pll_go_o,
  input logic lcd_en_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic tmo_hit
);
  // R2
  go_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_go_o) |-> pll_rst_o && $past(pll_rst_o));
  // R3
  go_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pll_go_o) && pll_rst_o) |-> !$past(go_pend_i));
  // R4
  lcd_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_en_o) |-> $past(locked_i) && pll_rst_o && pclk_free_o);
  // R4
  done_on_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(link_ok_i) && !busy_o && lcd_en_o);
  // R6
  err_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !pclk_free_o && !pll_rst_o && !pll_go_o && !lcd_en_o && !busy_o);
  // R7
  link_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_hit && lcd_en_o && !link_ok_i) |=> !lcd_en_o && pll_rst_o);
  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_go_o && start_i && !tmo_hit) |=> busy_o);
  // R9
  stop_bringup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en_o && busy_o && stop_i && !tmo_hit) |=> lcd_en_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o) |-> !lcd_en_o && !pll_go_o);
endmodule

bind link_bringup_seq lbs_checker u_chk (
  .clk (clk), .rst_n (rst_n), .start_i (start_i), .stop_i (stop_i),
  .go_pend_i (go_pend_i), .locked_i (locked_i), .link_ok_i (link_ok_i),
  .pclk_free_o (pclk_free_o), .pll_rst_o (pll_rst_o), .pll_go_o (pll_go_o),
  .lcd_en_o (lcd_en_o), .busy_o (busy_o), .done_o (done_o), .err_o (err_o),
  .tmo_hit (tmo_hit)
);

// File: tb/sim_link_bringup_seq.sv
`timescale 1ns/1ps
module sim_link_bringup_seq;
  localparam int SETTLE = 2;
  localparam int TMO    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0;
  logic go_pend_i = 1'b0, locked_i = 1'b0, link_ok_i = 1'b0;
  logic pclk_free_o, pll_rst_o, pll_go_o, lcd_en_o, busy_o, done_o, err_o;

  link_bringup_seq #(.SETTLE_CYCLES(SETTLE), .TMO_CYCLES(TMO)) u0 (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .stop_i (stop_i),
    .go_pend_i (go_pend_i), .locked_i (locked_i), .link_ok_i (link_ok_i),
    .pclk_free_o (pclk_free_o), .pll_rst_o (pll_rst_o), .pll_go_o (pll_go_o),
    .lcd_en_o (lcd_en_o), .busy_o (busy_o), .done_o (done_o), .err_o (err_o)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [6:0] v;
    int         gap;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic [6:0] vec;
  assign vec = {pclk_free_o, pll_rst_o, pll_go_o, lcd_en_o, busy_o, done_o, err_o};

  // link model knobs
  bit hang_go = 0, hang_lock = 0;
  int link_lat = 2;
  bit go_seen = 0;
  int gcnt = 0, lcnt = 0, dcnt = 0;

  always @(negedge clk) begin
    if (!rst_n || !pll_rst_o) begin
      go_seen = 0; go_pend_i = 1'b0; gcnt = 0; locked_i = 1'b0; lcnt = 0;
    end else begin
      if (pll_go_o && !go_seen) begin
        go_seen = 1; go_pend_i = 1'b1; gcnt = 0;
      end else if (go_pend_i && !hang_go) begin
        gcnt++;
        if (gcnt >= 3) go_pend_i = 1'b0;
      end
      if (go_seen && !pll_go_o && !go_pend_i && !hang_lock) begin
        lcnt++;
        if (lcnt >= 4) locked_i = 1'b1;
      end
    end
    if (!rst_n || !lcd_en_o) begin
      link_ok_i = 1'b0; dcnt = 0;
    end else begin
      dcnt++;
      if (dcnt >= link_lat) link_ok_i = 1'b1;
    end
  end

  // monitor: every change of the output vector pops one expected item
  logic [6:0] prev = '0;
  int last_cyc = 0;
  always @(negedge clk) begin
    if (rst_n && vec !== prev) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL unexpected change: actual %b expected no change", vec);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.v !== vec || (e.gap >= 0 && (cyc - last_cyc) != e.gap)) begin
          errors++;
          $display("FAIL %s: actual %b gap %0d expected %b gap %0d",
                   e.tag, vec, cyc - last_cyc, e.v, e.gap);
        end
      end
      prev = vec;
      last_cyc = cyc;
    end
  end

  task automatic push(input logic [6:0] v, input int gap, input string tag);
    exp_t e;
    e.v = v; e.gap = gap; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic pulse(input bit s, input bit p);
    @(negedge clk);
    start_i = s; stop_i = p;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic push_rise(input string tag);
    push(7'b1000100, -1, tag);
    push(7'b1100100, 1, "R2");
    push(7'b1110100, SETTLE, "R2");
  endtask

  task automatic push_disable();
    push(7'b1100100, -1, "R8");
    push(7'b0100100, 1, "R8");
    push(7'b0000000, 1, "R8");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    while (cyc < 20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vec == 7'b0, "R1", vec, 7'b0);

    // normal bring-up, with stray start/stop mid-sequence (R9)
    push_rise("R2");
    push(7'b1100100, -1, "R3");
    push(7'b1101100, -1, "R4");
    push(7'b1101010, 2, "R4");
    pulse(1, 0);
    repeat (3) @(negedge clk);
    pulse(1, 0);
    pulse(0, 1);
    drain();
    pulse(1, 0);
    repeat (5) @(negedge clk);
    chk(vec == 7'b1101010, "R9", vec, 7'b1101010);

    push_disable();
    pulse(0, 1);
    drain();

    // go stage timeout
    hang_go = 1;
    push_rise("R2");
    push(7'b1000100, TMO, "R6");
    push(7'b0000001, 1, "R6");
    pulse(1, 0);
    drain();
    hang_go = 0;
    chk(err_o == 1'b1, "R10", vec, 7'b0000001);

    // lock stage timeout; start clears the sticky flag
    hang_lock = 1;
    push_rise("R10");
    push(7'b1100100, -1, "R3");
    push(7'b1000100, TMO, "R5");
    push(7'b0000001, 1, "R6");
    pulse(1, 0);
    drain();
    hang_lock = 0;

    // link stage timeout
    link_lat = TMO + 1;
    push_rise("R10");
    push(7'b1100100, -1, "R3");
    push(7'b1101100, -1, "R4");
    push(7'b1100100, TMO, "R7");
    push(7'b1000100, 1, "R7");
    push(7'b0000001, 1, "R7");
    pulse(1, 0);
    drain();

    // stop in idle clears the error
    push(7'b0000100, -1, "R10");
    push(7'b0000000, 2, "R8");
    pulse(0, 1);
    drain();
    chk(err_o == 1'b0, "R10", vec, 7'b0);

    // status on the very timeout edge wins
    link_lat = TMO;
    push_rise("R2");
    push(7'b1100100, -1, "R3");
    push(7'b1101100, -1, "R4");
    push(7'b1101010, TMO, "R5");
    pulse(1, 0);
    drain();
    push_disable();
    pulse(0, 1);
    drain();

    // start and stop together in idle
    push(7'b0000100, -1, "R11");
    push(7'b0000000, 2, "R11");
    pulse(1, 1);
    drain();
    chk(vec == 7'b0, "R11", vec, 7'b0);

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R9: actual %0d pending items expected 0", q.size());
    end
    summary();
  end
endmodule